// File: doc/BRIEF.md
# Paletted Hardware Cursor Overlay

This block lays a 64x64 pixel cursor over a live video stream. On every clock it receives the coordinates of the pixel being scanned out, together with that pixel's RGB colour. One clock later it returns either the same video colour or a cursor colour. Cursor art lives in a byte-wide internal buffer that a write port loads. Each 48-byte row of the buffer holds two kinds of data. The first is a packed set of 4-bit colour indices. The second is a transparency bitmap stored in reverse column order. A 16-entry palette of 24-bit colours turns an index into an RGB value.

A byte-wide register port sets five things: the cursor position, the buffer base in 1 KiB units, the palette entries and the mode. Each position axis is a 16-bit value that carries a built-in offset of 64. The cursor's top-left pixel therefore lands at (posX - 64, posY - 64). A position of X = 0 parks the cursor off screen. Position, base and mode are staged and move into effect only on a frame-start pulse, so a frame never shows a half-moved cursor. Palette writes take effect at once.

Top module: `cursorOverlay`

## Requirements
- R1: After reset the overlay is disabled and vidOut equals vidIn of the previous clock.
- R2: The output is registered, and vidOut always reflects the inputs presented one clock earlier. Outside the cursor window, vidOut equals that earlier vidIn.
- R3: The cursor window covers columns posX-64 to posX-1 and rows posY-64 to posY-1. Window column c = pixX - (posX - 64) and row r = pixY - (posY - 64).
- R4: Row r starts at byte address base*1024 + 48*r. The index of column c is in byte c/2 of the row: the low nibble for even c and the high nibble for odd c.
- R5: Column c is transparent when bit 7-(c mod 8) of row byte 47-c/8 is 1. A transparent pixel shows vidIn. An opaque pixel shows the palette colour of its index.
- R6: Register 0x40+4*i+k writes palette entry i. Lane k=0 sets colour bits 7:0, k=1 sets bits 15:8 and k=2 sets bits 23:16. Palette writes act immediately.
- R7: Register 0x06 is the mode. A value of 4 enables the overlay, and any other value disables it so that vidOut passes vidIn.
- R8: When the active X position is 0, no pixel shows the cursor.
- R9: Writes to registers 0x00-0x06 change nothing visible until a clock in which frameStart is high. The new values apply to pixels presented after that clock.
- R10: Row bytes 32 to 39 have no effect on the rendered image.
- R11: The position registers are 0x00 (X low byte), 0x01 (X high byte), 0x02 (Y low byte) and 0x03 (Y high byte). 0x04 holds base address bits 17:10 and 0x05 bits 0-5 hold address bits 23:18. Buffer addresses wrap modulo the buffer size of 2^BUF_AW bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Register write data |
| bufWrEn | input | 1 | Cursor buffer write strobe |
| bufWrAddr | input | BUF_AW | Cursor buffer byte address |
| bufWrData | input | 8 | Cursor buffer write byte |
| frameStart | input | 1 | Frame start pulse, applies staged settings |
| pixX | input | 16 | Current pixel column |
| pixY | input | 16 | Current pixel row |
| vidIn | input | 24 | Incoming video colour |
| vidOut | output | 24 | Video colour with cursor applied |

## Verification
A wrong row base or nibble select shows at the ports as a misplaced palette colour. It appears in the very next output sample after the affected pixel. A wrong mask bit order swaps transparent and opaque pixels within a group of eight columns. A wrong window offset shifts the whole picture, which shows at the border pixels of the window on the first scanned row. A shadow register that leaks through before frameStart shows as cursor output, or its absence, one clock after a mid-frame write. The sweeps cover every window pixel plus a two-pixel border for two images, two bases and two positions, so each such error turns up within one sweep.

// File: rtl/cursorPkg.sv
package cursorPkg;
  localparam int CUR_DIM     = 64;
  localparam int ROW_BYTES   = 48;
  localparam int PAL_ENTRIES = 16;
  localparam int PAL_IW      = $clog2(PAL_ENTRIES);
  localparam int COLOR_W     = 24;
  localparam int POS_W       = 16;
  localparam int ADDR_FULL   = 24;
  localparam int UNIT_SHIFT  = 10;
  localparam int BASE_W      = ADDR_FULL - UNIT_SHIFT;
  localparam logic [7:0] MODE_PAL = 8'd4;

  localparam logic [7:0] REG_XLO  = 8'h00;
  localparam logic [7:0] REG_XHI  = 8'h01;
  localparam logic [7:0] REG_YLO  = 8'h02;
  localparam logic [7:0] REG_YHI  = 8'h03;
  localparam logic [7:0] REG_BLO  = 8'h04;
  localparam logic [7:0] REG_BHI  = 8'h05;
  localparam logic [7:0] REG_MODE = 8'h06;
  localparam logic [1:0] PAL_PAGE = 2'b01;

  typedef struct packed {
    logic              palWr;
    logic [PAL_IW-1:0] palIdx;
    logic [1:0]        palLane;
    logic [7:0]        palByte;
  } palStrobe_t;

  typedef struct packed {
    logic              en;
    logic [POS_W-1:0]  posX;
    logic [POS_W-1:0]  posY;
    logic [BASE_W-1:0] baseUnits;
  } liveCfg_t;
endpackage

// File: rtl/cursorCtrl.sv
module cursorCtrl
  import cursorPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       frameStart,
  output palStrobe_t palStb,
  output liveCfg_t   liveCfg
);
  logic [POS_W-1:0]  pendPosX;
  logic [POS_W-1:0]  pendPosY;
  logic [BASE_W-1:0] pendBase;
  logic [7:0]        pendMode;
  logic              unusedHiBits;

  assign unusedHiBits = ^regWrData[7:BASE_W-8];

  // staged register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendPosX <= '0;
      pendPosY <= '0;
      pendBase <= '0;
      pendMode <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        REG_XLO:  pendPosX[7:0]         <= regWrData;
        REG_XHI:  pendPosX[15:8]        <= regWrData;
        REG_YLO:  pendPosY[7:0]         <= regWrData;
        REG_YHI:  pendPosY[15:8]        <= regWrData;
        REG_BLO:  pendBase[7:0]         <= regWrData;
        REG_BHI:  pendBase[BASE_W-1:8]  <= regWrData[BASE_W-9:0];
        REG_MODE: pendMode              <= regWrData;
        default:  ;
      endcase
    end
  end

  // frame-aligned transfer into the live copy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveCfg <= '0;
    end else if (frameStart) begin
      liveCfg.en        <= (pendMode == MODE_PAL);
      liveCfg.posX      <= pendPosX;
      liveCfg.posY      <= pendPosY;
      liveCfg.baseUnits <= pendBase;
    end
  end

  // palette writes bypass the staging
  always_comb begin
    palStb.palWr   = regWrEn && (regAddr[7:6] == PAL_PAGE) && (regAddr[1:0] != 2'b11);
    palStb.palIdx  = regAddr[5:2];
    palStb.palLane = regAddr[1:0];
    palStb.palByte = regWrData;
  end
endmodule

// File: rtl/cursorDatapath.sv
module cursorDatapath
  import cursorPkg::*;
#(
  parameter int BUF_AW = 12
)(
  input  logic               clk,
  input  palStrobe_t         palStb,
  input  liveCfg_t           liveCfg,
  input  logic               bufWrEn,
  input  logic [BUF_AW-1:0]  bufWrAddr,
  input  logic [7:0]         bufWrData,
  input  logic [POS_W-1:0]   pixX,
  input  logic [POS_W-1:0]   pixY,
  input  logic [COLOR_W-1:0] vidIn,
  output logic [COLOR_W-1:0] vidOut
);
  localparam int BUF_BYTES = 1 << BUF_AW;
  localparam int DIM_W     = $clog2(CUR_DIM);
  localparam int REL_W     = POS_W + 1;

  logic [7:0] bufMem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (bufWrEn) bufMem[bufWrAddr] <= bufWrData;
  end

  // window-relative coordinates (position carries a +64 offset)
  logic [REL_W-1:0] relX, relY;
  logic             inWin;
  logic [DIM_W-1:0] col, row;

  assign relX  = {1'b0, pixX} + REL_W'(CUR_DIM) - {1'b0, liveCfg.posX};
  assign relY  = {1'b0, pixY} + REL_W'(CUR_DIM) - {1'b0, liveCfg.posY};
  assign inWin = liveCfg.en && (relX[REL_W-1:DIM_W] == '0) && (relY[REL_W-1:DIM_W] == '0);
  assign col   = relX[DIM_W-1:0];
  assign row   = relY[DIM_W-1:0];

  // byte addresses of the index byte and the mask byte
  logic [ADDR_FULL-1:0] rowBase, idxFull, mskFull;
  logic [BUF_AW-1:0]    idxAddr, mskAddr;
  logic                 unusedAddrBits;

  assign rowBase = {liveCfg.baseUnits, UNIT_SHIFT'(0)} + ADDR_FULL'(row) * ADDR_FULL'(ROW_BYTES);
  assign idxFull = rowBase + ADDR_FULL'(col[DIM_W-1:1]);
  assign mskFull = rowBase + ADDR_FULL'(ROW_BYTES - 1) - ADDR_FULL'(col[DIM_W-1:3]);
  assign idxAddr = idxFull[BUF_AW-1:0];
  assign mskAddr = mskFull[BUF_AW-1:0];
  assign unusedAddrBits = ^{idxFull[ADDR_FULL-1:BUF_AW], mskFull[ADDR_FULL-1:BUF_AW]};

  logic [7:0]        idxByte, mskByte;
  logic [PAL_IW-1:0] nib;
  logic              transp;

  assign idxByte = bufMem[idxAddr];
  assign mskByte = bufMem[mskAddr];
  assign nib     = col[0] ? idxByte[7:4] : idxByte[3:0];
  assign transp  = mskByte[3'd7 - col[2:0]];

  // palette: one byte lane per colour component
  logic [2:0][7:0] laneOut;

  for (genvar g = 0; g < 3; g++) begin : gLane
    logic [7:0] palMem [PAL_ENTRIES];
    always_ff @(posedge clk) begin
      if (palStb.palWr && (palStb.palLane == 2'(g)))
        palMem[palStb.palIdx] <= palStb.palByte;
    end
    assign laneOut[g] = palMem[nib];
  end

  always_ff @(posedge clk) begin
    vidOut <= (inWin && !transp) ? laneOut : vidIn;
  end
endmodule

// File: rtl/cursorOverlay.sv
module cursorOverlay
  import cursorPkg::*;
#(
  parameter int BUF_AW = 12
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [7:0]         regAddr,
  input  logic [7:0]         regWrData,
  input  logic               bufWrEn,
  input  logic [BUF_AW-1:0]  bufWrAddr,
  input  logic [7:0]         bufWrData,
  input  logic               frameStart,
  input  logic [POS_W-1:0]   pixX,
  input  logic [POS_W-1:0]   pixY,
  input  logic [COLOR_W-1:0] vidIn,
  output logic [COLOR_W-1:0] vidOut
);
  palStrobe_t palStb;
  liveCfg_t   liveCfg;

  cursorCtrl uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .frameStart(frameStart),
    .palStb(palStb), .liveCfg(liveCfg)
  );

  cursorDatapath #(.BUF_AW(BUF_AW)) uDp (
    .clk(clk), .palStb(palStb), .liveCfg(liveCfg),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .pixX(pixX), .pixY(pixY), .vidIn(vidIn), .vidOut(vidOut)
  );
endmodule

// File: rtl/cursorOverlayChk.sv
module cursorOverlayChk
  import cursorPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               frameStart,
  input logic [POS_W-1:0]   pixX,
  input logic [POS_W-1:0]   pixY,
  input logic [COLOR_W-1:0] vidIn,
  input logic [COLOR_W-1:0] vidOut,
  input liveCfg_t           liveCfg
);
  // R7: disabled overlay passes video unchanged
  a_r7_off_passes: assert property (@(posedge clk) disable iff (!rstN)
    !$past(liveCfg.en) |-> vidOut == $past(vidIn));

  // R8: X position zero hides the cursor
  a_r8_hidden: assert property (@(posedge clk) disable iff (!rstN)
    ($past(liveCfg.posX) == '0) |-> vidOut == $past(vidIn));

  // R3: columns at or right of posX are outside the window
  a_r3_right_edge: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pixX) >= $past(liveCfg.posX)) |-> vidOut == $past(vidIn));

  // R3: rows at or below posY are outside the window
  a_r3_bottom_edge: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pixY) >= $past(liveCfg.posY)) |-> vidOut == $past(vidIn));

  // R9: staged settings hold between frame starts
  a_r9_frame_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(liveCfg));
endmodule

bind cursorOverlay cursorOverlayChk uChk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .pixX(pixX),
  .pixY(pixY), .vidIn(vidIn), .vidOut(vidOut), .liveCfg(liveCfg)
);

// File: tb/sim_cursorOverlay.sv
module sim_cursorOverlay;
  localparam int CLK_PERIOD = 10;
  localparam int BUF_AW     = 12;
  localparam int BUF_BYTES  = 1 << BUF_AW;

  logic        clk = 0;
  logic        rstN = 0;
  logic        regWrEn = 0;
  logic [7:0]  regAddr = 0, regWrData = 0;
  logic        bufWrEn = 0;
  logic [BUF_AW-1:0] bufWrAddr = 0;
  logic [7:0]  bufWrData = 0;
  logic        frameStart = 0;
  logic [15:0] pixX = 0, pixY = 0;
  logic [23:0] vidIn = 0;
  logic [23:0] vidOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursorOverlay #(.BUF_AW(BUF_AW)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr),
    .bufWrData(bufWrData), .frameStart(frameStart), .pixX(pixX),
    .pixY(pixY), .vidIn(vidIn), .vidOut(vidOut)
  );

  function automatic int idxOf(int r, int c, int seed);
    return (r*3 + c + seed) % 16;
  endfunction

  function automatic bit trOf(int r, int c, int seed);
    return ((r*7 + c*5 + seed) % 11) == 0;
  endfunction

  function automatic logic [23:0] palCol(int i);
    return {8'(i*17), 8'(8'hA0 ^ i), 8'(8'h3C + i)};
  endfunction

  function automatic logic [23:0] vpat(int x, int y);
    return {8'(x), 8'(y), 8'h55};
  endfunction

  function automatic logic [23:0] expPix(int x, int y, int px, int py, int seed, bit en);
    int c, r;
    c = x - (px - 64);
    r = y - (py - 64);
    if (en && px != 0 && c >= 0 && c < 64 && r >= 0 && r < 64 && !trOf(r, c, seed))
      return palCol(idxOf(r, c, seed));
    return vpat(x, y);
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic regWr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic pulseFrame();
    @(negedge clk);
    frameStart = 1;
    @(negedge clk);
    frameStart = 0;
  endtask

  task automatic setPos(int px, int py);
    regWr(8'h00, 8'(px));
    regWr(8'h01, 8'(px >> 8));
    regWr(8'h02, 8'(py));
    regWr(8'h03, 8'(py >> 8));
  endtask

  // drive one pixel, sample the registered output one clock later
  task automatic pixel(int x, int y, output logic [23:0] o);
    @(negedge clk);
    pixX = 16'(x); pixY = 16'(y); vidIn = vpat(x, y);
    @(negedge clk);
    o = vidOut;
  endtask

  task automatic loadImage(int baseUnits, int seed, logic [7:0] fill);
    for (int r = 0; r < 64; r++) begin
      for (int b = 0; b < 48; b++) begin
        logic [7:0] v;
        if (b < 32) begin
          v = {4'(idxOf(r, 2*b+1, seed)), 4'(idxOf(r, 2*b, seed))};
        end else if (b < 40) begin
          v = fill;
        end else begin
          for (int j = 0; j < 8; j++) v[7-j] = trOf(r, 8*(47-b) + j, seed);
        end
        @(negedge clk);
        bufWrEn = 1;
        bufWrAddr = BUF_AW'((baseUnits*1024 + r*48 + b) % BUF_BYTES);
        bufWrData = v;
      end
    end
    @(negedge clk);
    bufWrEn = 0;
  endtask

  task automatic sweep(int px, int py, int seed, bit en, string req);
    logic [23:0] o;
    for (int y = py - 66; y <= py + 1; y++) begin
      for (int x = px - 66; x <= px + 1; x++) begin
        if (x >= 0 && y >= 0) begin
          pixel(x, y, o);
          check(req, o, expPix(x, y, px, py, seed, en));
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual running expected finished");
    finishRun();
  end

  initial begin
    logic [23:0] o;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state passes video
    pixel(5, 5, o);
    check("R1 reset pass", o, vpat(5, 5));
    pixel(36, 16, o);
    check("R1 reset pass", o, vpat(36, 16));

    // R6: palette lanes
    for (int i = 0; i < 16; i++) begin
      logic [23:0] pc;
      pc = palCol(i);
      regWr(8'(8'h40 + 4*i + 0), pc[7:0]);
      regWr(8'(8'h40 + 4*i + 1), pc[15:8]);
      regWr(8'(8'h40 + 4*i + 2), pc[23:16]);
    end

    loadImage(1, 0, 8'hFF);
    setPos(100, 80);
    regWr(8'h04, 8'd1);
    regWr(8'h05, 8'd0);
    regWr(8'h06, 8'd4);

    // R9: nothing until frame start
    pixel(50, 30, o);
    check("R9 before frame", o, vpat(50, 30));
    pulseFrame();

    // R2 R3 R4 R5 R6 R10: full window plus border
    sweep(100, 80, 0, 1, "R2 R3 R4 R5 R6 R10 window");

    // R9: mid-frame move stays invisible
    regWr(8'h00, 8'd200);
    pixel(50, 30, o);
    check("R9 staged move", o, expPix(50, 30, 100, 80, 0, 1));
    pulseFrame();
    pixel(50, 30, o);
    check("R9 applied move", o, vpat(50, 30));
    pixel(150, 30, o);
    check("R9 applied move", o, expPix(150, 30, 200, 80, 0, 1));

    // R7: other mode values disable
    regWr(8'h06, 8'd5);
    pulseFrame();
    pixel(150, 30, o);
    check("R7 mode 5", o, vpat(150, 30));
    regWr(8'h06, 8'd0);
    pulseFrame();
    pixel(151, 31, o);
    check("R7 mode 0", o, vpat(151, 31));
    regWr(8'h06, 8'd4);
    pulseFrame();
    pixel(151, 31, o);
    check("R7 mode 4", o, expPix(151, 31, 200, 80, 0, 1));

    // R8: X position zero hides
    regWr(8'h00, 8'd0);
    regWr(8'h01, 8'd0);
    pulseFrame();
    for (int x = 0; x < 80; x++) begin
      pixel(x, 30, o);
      check("R8 hidden", o, vpat(x, 30));
    end

    // R11: high bytes, wrapped base, R10 with other filler
    loadImage(3, 5, 8'h00);
    setPos(336, 288);
    regWr(8'h04, 8'd3);
    pulseFrame();
    sweep(336, 288, 5, 1, "R11 R4 R5 R10 wrapped base");

    // R6: palette write acts without frame start
    begin
      int c, r;
      logic [23:0] want;
      c = 0; r = 0;
      while (trOf(r, c, 5)) c++;
      regWr(8'(8'h40 + 4*idxOf(r, c, 5) + 1), 8'h5A);
      want = palCol(idxOf(r, c, 5));
      want[15:8] = 8'h5A;
      pixel(336 - 64 + c, 288 - 64 + r, o);
      check("R6 immediate palette", o, want);
    end

    finishRun();
  end
endmodule